// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block sequences parallel-mode programming of two small on-chip arrays: a code array and a data array, both modelled as registers and both blank (all ones) after reset. An external programmer presents an address, a byte, an array select and a three-bit operation code, then pulses an active-low program strobe. The block then runs one of these operations: a self-timed byte write, a verify read, a chip erase, a signature read, lock-bit programming, lock-bit readout, or setting the fuse that disables serial programming.

A byte write never erases first. The new byte is ANDed into the cell, so a location that is not blank has to go through a chip erase before it can take arbitrary data again. Progress is reported in two ways. A ready line drops for the length of the write. While the write is in progress, reading the address being written returns the final byte with bit 7 inverted. A chip erase only takes effect if the strobe is held low for a set number of clock cycles. Write and erase durations are parameters counted in clock cycles.

The bidirectional data pins are split into `data_in`, `data_out` and an output enable `data_oe`. The pad tristate lies outside this block.

Top module: `pflash_prog_seq`

## Requirements
- R1: After reset, `rdy` is 1, `data_oe` is 0, `ser_dis` is 0, both lock bits are clear and every location of both arrays reads FFh.
- R2: An operation code is sampled on the clock edge where `strobe_n` is seen high after being low. If the code is WRITE (1) and the block is ready, `rdy` goes low after that edge. It stays low for exactly WRITE_CYC clock cycles.
- R3: A completed write stores the old contents ANDed with `data_in`. Bits that are already 0 stay 0.
- R4: While a write is in progress, READ (2) of the same array and address returns the final byte with bit 7 inverted. Once `rdy` is back high, the true byte is returned.
- R5: A WRITE strobe that arrives while `rdy` is low is ignored. It changes no location and does not extend the busy period.
- R6: Chip erase needs `cmd` = ERASE (3) with `strobe_n` held low for ERASE_CYC consecutive clock edges. It sets both arrays to FFh and clears both lock bits. A shorter hold changes nothing, and `rdy` stays high throughout.
- R7: READ (2) returns the code array when `arr_sel` = 0 and the data array when `arr_sel` = 1. The data array is indexed by the low log2(DATA_DEPTH) address bits.
- R8: A LOCKP (5) strobe sets lock bits 1:0 to their old value ORed with `data_in[1:0]`. LOCKRD (6) drives {6'b0, lock[1:0]}.
- R9: While either lock bit is set, READ drives 00h and starts no operation, so `rdy` stays high.
- R10: SIG (4) at address 30h drives 1Eh, at address 31h drives 82h, and at any other address drives 00h.
- R11: A FUSE (7) strobe sets `ser_dis` to `data_in[0]`. Chip erase leaves `ser_dis` unchanged.
- R12: `data_oe` is 1 exactly when `strobe_n` is high and `cmd` is READ, SIG or LOCKRD. Otherwise `data_out` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Byte address (AW = log2(CODE_DEPTH)) |
| arr_sel | input | 1 | 0 selects the code array, 1 selects the data array |
| cmd | input | 3 | Operation code |
| strobe_n | input | 1 | Active-low program strobe |
| data_in | input | 8 | Byte driven by the programmer |
| data_out | output | 8 | Byte driven toward the pins |
| data_oe | output | 1 | Output enable for `data_out` |
| rdy | output | 1 | High when ready, low while a write is in progress |
| ser_dis | output | 1 | Fuse state: serial programming disabled |

## Verification
Every code and data location is written, then written a second time with a different pattern. The bench checks the AND result, the inverted bit 7 during each write, and the exact busy length on each write. A design that erased before writing, or that committed the byte at the start of the write, would miss those checks. An erase held one cycle short must leave both arrays intact, and a full-length hold must blank them and the lock bits. A second write strobe during busy must leave its target untouched, which catches a sequencer that restarts or queues. The full address sweep in signature mode catches decoding that is too loose. The locked read checks catch any leak of array data, and any case where a blocked read drops `rdy`.

// File: rtl/pflash_pkg.sv
// Shared operation codes and identification bytes for the programming sequencer.
package pflash_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_SIG    = 3'd4,
        OP_LOCKP  = 3'd5,
        OP_LOCKRD = 3'd6,
        OP_FUSE   = 3'd7
    } op_e;

    localparam logic [7:0] SIG_BYTE0 = 8'h1E;
    localparam logic [7:0] SIG_BYTE1 = 8'h82;
    localparam int         SIG_ADDR0 = 48;
    localparam int         SIG_ADDR1 = 49;
endpackage

// File: rtl/pflash_array.sv
// Register model of one flash array.
// Writes AND the new byte into the cell, because there is no per-byte erase.
// Erase sets every cell to FFh. Reads are combinational.
// Assumes that erase and write are never requested in the same cycle.
module pflash_array #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          erase,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    // Cell update: blank on reset or erase, otherwise AND in the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    // Read port.
    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/pflash_wr_timer.sv
// Self-timed write duration counter.
// A start request raises busy for exactly CYC cycles.
// done is high in the final busy cycle, and that is when the byte is committed.
// Assumes the caller drops start while busy.
module pflash_wr_timer #(
    parameter int CYC = 8,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] remain;

    // Count down the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CYC - 1);
        end
    end

    // Commit strobe in the final busy cycle.
    assign done = busy && (remain == '0);
endmodule

// File: rtl/pflash_erase_timer.sv
// Measures how long the strobe is held low for an erase.
// Pulses fire once, on the CYC-th consecutive held edge.
// A release before that clears the count and has no effect.
module pflash_erase_timer #(
    parameter int CYC = 16,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic fire
);
    logic [CW-1:0] held;
    logic          spent;

    // Count held edges; remember that the erase has fired until release.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold) begin
            held  <= '0;
            spent <= 1'b0;
        end else if (!spent) begin
            if (held == CW'(CYC - 1)) spent <= 1'b1;
            else                      held  <= held + 1'b1;
        end
    end

    // One-cycle erase request.
    assign fire = hold && !spent && (held == CW'(CYC - 1));
endmodule

// File: rtl/pflash_prog_seq.sv
// Parallel programming sequencer for a code array and a data array.
// Decodes the operation code, starts timed writes on the strobe's rising edge,
// times chip erase from the strobe low width, and drives the read path.
// The read path covers data polling, the lock block and the signature bytes.
// Assumes DATA_DEPTH <= CODE_DEPTH and CODE_DEPTH >= 64 for signature decoding.
module pflash_prog_seq
    import pflash_pkg::*;
#(
    parameter int CODE_DEPTH = 64,
    parameter int DATA_DEPTH = 32,
    parameter int WRITE_CYC  = 5,
    parameter int ERASE_CYC  = 20,
    localparam int AW  = $clog2(CODE_DEPTH),
    localparam int DAW = $clog2(DATA_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          arr_sel,
    input  logic [2:0]    cmd,
    input  logic          strobe_n,
    input  logic [7:0]    data_in,
    output logic [7:0]    data_out,
    output logic          data_oe,
    output logic          rdy,
    output logic          ser_dis
);
    op_e           op;
    logic          strobe_q;
    logic          rise;
    logic          busy;
    logic          commit;
    logic          erase_fire;
    logic          wr_start;
    logic [AW-1:0] pend_addr;
    logic [7:0]    pend_data;
    logic          pend_arr;
    logic [1:0]    lock_q;
    logic          fuse_q;
    logic [7:0]    code_rd;
    logic [7:0]    dat_rd;
    logic [7:0]    sel_rd;
    logic          poll_hit;

    assign op       = op_e'(cmd);
    assign rise     = strobe_n && !strobe_q;
    assign wr_start = rise && (op == OP_WRITE) && !busy;

    // Previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n;
    end

    // Capture the write target when a write starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_data <= 8'hFF;
            pend_arr  <= 1'b0;
        end else if (wr_start) begin
            pend_addr <= addr;
            pend_data <= data_in;
            pend_arr  <= arr_sel;
        end
    end

    // Lock bits: OR-programmed by strobe, cleared only by chip erase.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_fire)                  lock_q <= 2'b00;
        else if (rise && op == OP_LOCKP && !busy)  lock_q <= lock_q | data_in[1:0];
    end

    // Serial-disable fuse: set or cleared here only, untouched by erase.
    always_ff @(posedge clk) begin
        if (!rst_n)                                fuse_q <= 1'b0;
        else if (rise && op == OP_FUSE && !busy)   fuse_q <= data_in[0];
    end

    pflash_wr_timer #(.CYC(WRITE_CYC)) u_wr_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_start),
        .busy  (busy),
        .done  (commit)
    );

    pflash_erase_timer #(.CYC(ERASE_CYC)) u_erase_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (!strobe_n && op == OP_ERASE && !busy),
        .fire  (erase_fire)
    );

    pflash_array #(.DEPTH(CODE_DEPTH)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit && !pend_arr),
        .wr_addr (pend_addr),
        .wr_data (pend_data),
        .erase   (erase_fire),
        .rd_addr (addr),
        .rd_data (code_rd)
    );

    pflash_array #(.DEPTH(DATA_DEPTH)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit && pend_arr),
        .wr_addr (pend_addr[DAW-1:0]),
        .wr_data (pend_data),
        .erase   (erase_fire),
        .rd_addr (addr[DAW-1:0]),
        .rd_data (dat_rd)
    );

    assign sel_rd = arr_sel ? dat_rd : code_rd;

    // Detect a read of the byte currently being written.
    always_comb begin
        poll_hit = 1'b0;
        if (busy && arr_sel == pend_arr) begin
            if (arr_sel) poll_hit = (addr[DAW-1:0] == pend_addr[DAW-1:0]);
            else         poll_hit = (addr == pend_addr);
        end
    end

    // Output mux: verify read with polling, signature, lock readout.
    always_comb begin
        data_out = 8'h00;
        data_oe  = 1'b0;
        if (strobe_n) begin
            case (op)
                OP_READ: begin
                    data_oe = 1'b1;
                    if (lock_q != 2'b00) data_out = 8'h00;
                    else if (poll_hit)   data_out = (sel_rd & pend_data) ^ 8'h80;
                    else                 data_out = sel_rd;
                end
                OP_SIG: begin
                    data_oe = 1'b1;
                    if (addr == AW'(SIG_ADDR0))      data_out = SIG_BYTE0;
                    else if (addr == AW'(SIG_ADDR1)) data_out = SIG_BYTE1;
                    else                             data_out = 8'h00;
                end
                OP_LOCKRD: begin
                    data_oe  = 1'b1;
                    data_out = {6'b0, lock_q};
                end
                default: begin
                    data_oe  = 1'b0;
                    data_out = 8'h00;
                end
            endcase
        end
    end

    assign rdy     = !busy;
    assign ser_dis = fuse_q;
endmodule

// File: rtl/pflash_prog_seq_chk.sv
// Property checker for the programming sequencer, bound to the top module.
// Observes ports and the lock register; holds a counter for the busy window.
module pflash_prog_seq_chk #(
    parameter int WRITE_CYC = 5,
    parameter int AW        = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd,
    input logic          strobe_n,
    input logic [AW-1:0] addr,
    input logic [7:0]    data_out,
    input logic          data_oe,
    input logic          rdy,
    input logic [1:0]    lock
);
    int low_run;

    // Length of the current run of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    low_run <= 0;
        else if (!rdy) low_run <= low_run + 1;
        else           low_run <= 0;
    end

    // R2
    rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> ($past(cmd) == 3'd1 && $past(strobe_n)));

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= WRITE_CYC);

    // R9
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2 && strobe_n && lock != 2'b00) |-> data_out == 8'h00);

    // R10
    sig_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4 && strobe_n && addr == AW'(48)) |-> data_out == 8'h1E);

    // R12
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> strobe_n);
endmodule

bind pflash_prog_seq pflash_prog_seq_chk #(.WRITE_CYC(WRITE_CYC), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .strobe_n (strobe_n),
    .addr     (addr),
    .data_out (data_out),
    .data_oe  (data_oe),
    .rdy      (rdy),
    .lock     (lock_q)
);

// File: tb/pflash_prog_seq_tb.sv
// Self-checking bench: sweeps every location of both arrays through write, AND-rewrite,
// polling and busy length; then signature, erase, lock and fuse behaviour.
module pflash_prog_seq_tb;
    localparam int CD = 64;
    localparam int DD = 32;
    localparam int WC = 5;
    localparam int EC = 20;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          arr_sel = 1'b0;
    logic [2:0]    cmd = 3'd0;
    logic          strobe_n = 1'b1;
    logic [7:0]    data_in = 8'h00;
    logic [7:0]    data_out;
    logic          data_oe;
    logic          rdy;
    logic          ser_dis;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] code_m [CD];
    logic [7:0] data_m [DD];

    pflash_prog_seq #(.CODE_DEPTH(CD), .DATA_DEPTH(DD), .WRITE_CYC(WC), .ERASE_CYC(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .arr_sel(arr_sel), .cmd(cmd),
        .strobe_n(strobe_n), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .rdy(rdy), .ser_dis(ser_dis)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Strobe pulse: low for one edge, then high; the rise is sampled on the next edge.
    task automatic strobe_op(input logic [2:0] c, input int a, input logic s, input logic [7:0] d);
        @(negedge clk);
        cmd = c; addr = AW'(a); arr_sel = s; data_in = d; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_at(input logic [2:0] c, input int a, input logic s, output logic [7:0] v);
        @(negedge clk);
        cmd = c; addr = AW'(a); arr_sel = s;
        #1 v = data_out;
    endtask

    function automatic logic [7:0] model_rd(input int a, input logic s);
        return s ? data_m[a] : code_m[a];
    endfunction

    // Full write with polling and busy-length checks; updates the model.
    task automatic write_chk(input int a, input logic s, input logic [7:0] d);
        logic [7:0] fin;
        int low;
        fin = model_rd(a, s) & d;
        strobe_op(3'd1, a, s, d);
        cmd = 3'd2;
        #1;
        chk("R4 poll", data_out, fin ^ 8'h80);
        low = 0;
        while (!rdy && low < 100) begin
            low++;
            @(negedge clk);
            #1;
        end
        chk("R2 busy len", low, WC);
        if (s) data_m[a] = fin; else code_m[a] = fin;
        chk("R3/R4 true data", data_out, fin);
    endtask

    task automatic erase_hold(input int n);
        @(negedge clk);
        cmd = 3'd3; strobe_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R6 rdy high", rdy, 1);
        end
        strobe_n = 1'b1;
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic verify_all(input string req);
        logic [7:0] v;
        for (int a = 0; a < CD; a++) begin
            read_at(3'd2, a, 1'b0, v);
            chk(req, v, code_m[a]);
        end
        for (int a = 0; a < DD; a++) begin
            read_at(3'd2, a, 1'b1, v);
            chk(req, v, data_m[a]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        for (int i = 0; i < CD; i++) code_m[i] = 8'hFF;
        for (int i = 0; i < DD; i++) data_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 rdy", rdy, 1);
        chk("R1 oe", data_oe, 0);
        chk("R1 ser_dis", ser_dis, 0);
        verify_all("R1 blank");
        read_at(3'd6, 0, 1'b0, v);
        chk("R1 lock clear", v, 0);

        // R7/R3 first pass over both arrays, then AND rewrite
        for (int a = 0; a < CD; a++) write_chk(a, 1'b0, 8'(a * 29 + 7));
        for (int a = 0; a < DD; a++) write_chk(a, 1'b1, 8'(a * 53 + 200));
        verify_all("R7 readback");
        for (int a = 0; a < CD; a++) write_chk(a, 1'b0, 8'(a * 13 + 90));
        for (int a = 0; a < DD; a++) write_chk(a, 1'b1, 8'(a * 71 + 3));
        verify_all("R3 and");

        // R5 write strobe during busy is ignored
        write_chk(5, 1'b0, 8'h00);
        strobe_op(3'd1, 6, 1'b0, 8'h00);
        strobe_op(3'd1, 9, 1'b0, 8'h00);
        while (!rdy) @(negedge clk);
        repeat (3) @(negedge clk);
        #1 chk("R5 no restart", rdy, 1);
        code_m[6] = code_m[6] & 8'h00;
        read_at(3'd2, 9, 1'b0, v);
        chk("R5 ignored", v, code_m[9]);
        read_at(3'd2, 6, 1'b0, v);
        chk("R5 first done", v, code_m[6]);

        // R12 output enable gating
        read_at(3'd0, 3, 1'b0, v);
        chk("R12 nop oe", data_oe, 0);
        chk("R12 nop data", v, 0);
        @(negedge clk);
        cmd = 3'd2; strobe_n = 1'b0;
        #1 chk("R12 strobe low oe", data_oe, 0);
        strobe_n = 1'b1;
        read_at(3'd4, 0, 1'b0, v);
        chk("R12 sig oe", data_oe, 1);

        // R10 signature sweep
        for (int a = 0; a < CD; a++) begin
            read_at(3'd4, a, 1'b0, v);
            chk("R10 sig", v, a == 48 ? 8'h1E : (a == 49 ? 8'h82 : 8'h00));
        end

        // R11 fuse set before erase
        strobe_op(3'd7, 0, 1'b0, 8'h01);
        chk("R11 fuse set", ser_dis, 1);

        // R6 short hold leaves contents; full hold blanks them
        erase_hold(EC - 1);
        verify_all("R6 short hold");
        erase_hold(EC);
        for (int i = 0; i < CD; i++) code_m[i] = 8'hFF;
        for (int i = 0; i < DD; i++) data_m[i] = 8'hFF;
        verify_all("R6 erased");
        chk("R11 fuse kept", ser_dis, 1);
        strobe_op(3'd7, 0, 1'b0, 8'h00);
        chk("R11 fuse clear", ser_dis, 0);

        // R8/R9 lock program, blocked reads, erase clears lock
        write_chk(20, 1'b0, 8'h3C);
        strobe_op(3'd5, 0, 1'b0, 8'h01);
        read_at(3'd6, 0, 1'b0, v);
        chk("R8 lock rd", v, 8'h01);
        strobe_op(3'd5, 0, 1'b0, 8'h02);
        read_at(3'd6, 0, 1'b0, v);
        chk("R8 lock or", v, 8'h03);
        strobe_op(3'd2, 20, 1'b0, 8'h00);
        #1 chk("R9 blocked", data_out, 0);
        chk("R9 rdy", rdy, 1);
        read_at(3'd2, 20, 1'b1, v);
        chk("R9 blocked data", v, 0);
        erase_hold(EC);
        code_m[20] = 8'hFF;
        read_at(3'd6, 0, 1'b0, v);
        chk("R6 lock cleared", v, 0);
        read_at(3'd2, 20, 1'b0, v);
        chk("R6 unlocked blank", v, 8'hFF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule